// File: doc/BRIEF.md
# Supply-Modulation Programming Decoder

This block turns a train of event strobes, recovered from a modulated supply rail by an analog front end, into programming actions for a small one-time storage array. It runs on the 32768 Hz timebase, with one tick per clock. A start event opens an instruction session. Small pulses then carry commands, and each command is encoded only by how many ticks separate it from the previous small pulse. A short gap advances the instruction state. A medium gap shifts a 0 into an 8-bit data register, and a long gap shifts a 1.

In states 3 and 4, a prestore event followed by a store event commits the register to the selected word. Each word accepts only one commit. For readback, a single 1 is clocked in and then walked through the register with 0-clocks. The readback output is high while the stored bit under that 1 is set.

A session closes on a stop event, on a store event, or after a long period with no small pulse. The type-code word and the unused word are read only.

Top module: `supply_prog_decoder`

## Requirements
- R1: A start event, which takes priority over every other event, sets `state` to 1 and clears `shreg` to 0 in the following cycle.
- R2: Small pulses that arrive fewer than INIT_WAIT (default 820) ticks after the start strobe are ignored. The first small pulse at or after that point changes nothing visible and only becomes the timing reference.
- R3: A small pulse whose gap from the previous small pulse is 20 to 26 ticks increments `state` by one. At state 6, `state` holds at 6.
- R4: A gap of 52 to 59 ticks shifts a 0 into `shreg`, and a gap of 85 to 92 ticks shifts a 1. The new bit enters at bit 7 and the rest move one place toward bit 0, so after eight shifts the first bit sent sits in bit 0 (LSB) and the last sent sits in bit 7 (MSB).
- R5: A small pulse whose gap lies outside all three windows leaves `state` and `shreg` unchanged, but later gaps are measured from it.
- R6: A prestore event, followed later in the same session by a store event while `state` is 3 (word A) or 4 (word B), writes `shreg` into that word. In that case `wr_stb` is high for exactly the one cycle after the store strobe.
- R7: A store with no earlier prestore in the session, a store in states 1, 2, 5 or 6, or a second store to a word that has already been written does not raise `wr_stb` and leaves the stored word unchanged.
- R8: A stop event or a store event sets `state` to 0 in the next cycle. With no small pulse, `state` also falls to 0 exactly TIMEOUT ticks (default 65536, 2 s) after the last small pulse, or after the start strobe if no small pulse has been counted since.
- R9: `rd_load` is high only when `state` is 3 to 6 and `shreg` AND the selected word is non-zero. Word C (state 5) always reads 0, and word D (state 6) reads TYPE_CODE.
- R10: After reset, `state`, `shreg`, `wr_stb` and `rd_load` are all 0, and words A and B are 0 and unwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Large start pulse detected (one-cycle strobe) |
| ev_stop | input | 1 | Stop pulse detected |
| ev_pulse | input | 1 | Small modulation pulse detected |
| ev_prestore | input | 1 | Prestore pulse detected |
| ev_store | input | 1 | Store pulse detected |
| state | output | 3 | Instruction state: 0 idle, 1 to 6 active |
| shreg | output | 8 | Data and pointer shift register |
| wr_stb | output | 1 | One-cycle strobe marking a word commit |
| rd_load | output | 1 | Readback load enable, high while the addressed stored bit is 1 |

## Verification
The assertions check the following on every cycle:
- what a start, a stop or a store does to the state;
- that the state never exceeds 6 and moves at most one step at a time within a session;
- that the write strobe lasts a single cycle and appears only after state 3 or 4;
- that the load enable stays low when idle.

Only the bench's scenarios can show:
- where the gap windows begin and end, and that the start-up wait ends on exactly the right tick;
- the bit order in the register and the content a walking-one readback returns;
- that a word refuses a second commit;
- that the session ends on exactly the right tick of the long timeout.

// File: rtl/supply_prog_decoder.sv
module supply_prog_decoder #(
  parameter int INIT_WAIT = 820,
  parameter int TIMEOUT   = 65536,
  parameter int INC_LO    = 20,
  parameter int INC_HI    = 26,
  parameter int ZERO_LO   = 52,
  parameter int ZERO_HI   = 59,
  parameter int ONE_LO    = 85,
  parameter int ONE_HI    = 92,
  parameter logic [7:0] TYPE_CODE = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_pulse,
  input  logic       ev_prestore,
  input  logic       ev_store,
  output logic [2:0] state,
  output logic [7:0] shreg,
  output logic       wr_stb,
  output logic       rd_load
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] WAIT_C = CW'(INIT_WAIT);
  localparam logic [CW-1:0] TO_C   = CW'(TIMEOUT);
  localparam logic [CW-1:0] IL = CW'(INC_LO),  IH = CW'(INC_HI);
  localparam logic [CW-1:0] ZL = CW'(ZERO_LO), ZH = CW'(ZERO_HI);
  localparam logic [CW-1:0] OL = CW'(ONE_LO),  OH = CW'(ONE_HI);

  logic [CW-1:0] gap;
  logic          ref_seen, armed;
  logic [7:0]    word_a, word_b, sel_word;
  logic          used_a, used_b;

  wire active   = state != 3'd0;
  wire expired  = active && gap == TO_C;
  wire is_inc   = gap >= IL && gap <= IH;
  wire is_zero  = gap >= ZL && gap <= ZH;
  wire is_one   = gap >= OL && gap <= OH;
  wire commit   = ev_store && armed &&
                  ((state == 3'd3 && !used_a) || (state == 3'd4 && !used_b));

  always_comb begin
    case (state)
      3'd3:    sel_word = word_a;
      3'd4:    sel_word = word_b;
      3'd6:    sel_word = TYPE_CODE;
      default: sel_word = 8'h00;
    endcase
  end

  assign rd_load = |(shreg & sel_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= 3'd0;
      shreg    <= 8'h00;
      gap      <= '0;
      ref_seen <= 1'b0;
      armed    <= 1'b0;
      wr_stb   <= 1'b0;
      word_a   <= 8'h00;
      word_b   <= 8'h00;
      used_a   <= 1'b0;
      used_b   <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (ev_start) begin
        state    <= 3'd1;
        shreg    <= 8'h00;
        gap      <= CW'(1);
        ref_seen <= 1'b0;
        armed    <= 1'b0;
      end else if (active) begin
        if (ev_stop || expired) begin
          state <= 3'd0;
          armed <= 1'b0;
        end else if (ev_store) begin
          state <= 3'd0;
          armed <= 1'b0;
          if (commit) begin
            wr_stb <= 1'b1;
            if (state == 3'd3) begin
              word_a <= shreg;
              used_a <= 1'b1;
            end else begin
              word_b <= shreg;
              used_b <= 1'b1;
            end
          end
        end else begin
          if (ev_prestore) armed <= 1'b1;
          if (ev_pulse && ref_seen) begin
            gap <= CW'(1);
            if (is_inc && state != 3'd6) state <= state + 3'd1;
            if (is_zero) shreg <= {1'b0, shreg[7:1]};
            if (is_one)  shreg <= {1'b1, shreg[7:1]};
          end else if (ev_pulse && gap >= WAIT_C) begin
            ref_seen <= 1'b1;
            gap      <= CW'(1);
          end else begin
            gap <= gap + CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/supply_prog_decoder_chk.sv
module supply_prog_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_store,
  input logic [2:0] state,
  input logic [7:0] shreg,
  input logic       wr_stb,
  input logic       rd_load
);
  AST_START_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (state == 3'd1 && shreg == 8'h00)); // R1
  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'd6); // R3
  AST_STATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 3'd0 && $past(state) != 3'd0 && !$past(ev_start)) |->
      (state == $past(state) || state == $past(state) + 3'd1)); // R3
  AST_WR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(state) == 3'd3 || $past(state) == 3'd4)); // R6
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R6
  AST_END_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_stop || ev_store) && !ev_start) |=> state == 3'd0); // R8
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 || state == 3'd1 || state == 3'd2) |-> !rd_load); // R9
endmodule

bind supply_prog_decoder supply_prog_decoder_chk u_chk (.*);

// File: tb/tb_supply_prog_decoder.sv
module tb_supply_prog_decoder;
  localparam int TO = 65536;
  localparam logic [7:0] TC = 8'hC3;
  logic clk = 0, rst_n = 0;
  logic ev_start = 0, ev_stop = 0, ev_pulse = 0, ev_prestore = 0, ev_store = 0;
  logic [2:0] state;
  logic [7:0] shreg;
  logic wr_stb, rd_load;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  supply_prog_decoder #(.TIMEOUT(TO), .TYPE_CODE(TC)) dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_pulse(ev_pulse), .ev_prestore(ev_prestore), .ev_store(ev_store),
    .state(state), .shreg(shreg), .wr_stb(wr_stb), .rd_load(rd_load));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input int k);
    case (k)
      0: ev_start = 1;
      1: ev_stop = 1;
      2: ev_pulse = 1;
      3: ev_prestore = 1;
      default: ev_store = 1;
    endcase
    @(negedge clk);
    ev_start = 0; ev_stop = 0; ev_pulse = 0; ev_prestore = 0; ev_store = 0;
  endtask

  task automatic gap_pulse(input int d);
    repeat (d - 1) @(negedge clk);
    strobe(2);
  endtask

  task automatic open_state(input int n);
    strobe(0);
    gap_pulse(820);
    for (int i = 1; i < n; i++) gap_pulse(22);
  endtask

  task automatic load_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) gap_pulse(v[i] ? 88 : 55);
  endtask

  task automatic write_word(input int n, input logic [7:0] v, input bit pre, input bit exp_wr);
    open_state(n);
    load_byte(v);
    chk("R4 shreg after byte", shreg, v);
    if (pre) strobe(3);
    strobe(4);
    chk("R6/R7 wr_stb after store", wr_stb, exp_wr);
    chk("R8 state after store", state, 0);
    @(negedge clk);
    chk("R6 wr_stb single cycle", wr_stb, 0);
  endtask

  task automatic read_word(input int n, input logic [7:0] exp);
    open_state(n);
    gap_pulse(88);
    chk("R9 readback bit 7", rd_load, exp[7]);
    for (int i = 6; i >= 0; i--) begin
      gap_pulse(55);
      chk("R9 readback bit", rd_load, exp[i]);
    end
    strobe(1);
    chk("R8 stop ends session", state, 0);
    chk("R9 rd_load idle", rd_load, 0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [2:0] es;
    logic [7:0] er;
    @(negedge clk);
    chk("R10 reset state", state, 0);
    chk("R10 reset shreg", shreg, 0);
    chk("R10 reset wr_stb", wr_stb, 0);
    chk("R10 reset rd_load", rd_load, 0);
    rst_n = 1;
    @(negedge clk);

    strobe(0);
    chk("R1 start state", state, 1);
    gap_pulse(21);
    chk("R2 pulse in wait ignored", state, 1);
    gap_pulse(798);
    chk("R2 pulse at 819 ignored", state, 1);
    gap_pulse(1);
    chk("R2 reference only", state, 1);
    chk("R2 reference shreg", shreg, 0);
    gap_pulse(21);
    chk("R3 increment after reference", state, 2);

    es = 2; er = 0;
    for (int d = 1; d <= 100; d++) begin
      gap_pulse(d);
      if (d >= 20 && d <= 26 && es != 6) es = es + 1;
      if (d >= 52 && d <= 59) er = {1'b0, er[7:1]};
      if (d >= 85 && d <= 92) er = {1'b1, er[7:1]};
      chk("R3/R5 sweep state", state, es);
      chk("R4/R5 sweep shreg", shreg, er);
    end
    chk("R3 saturated at 6", state, 6);
    strobe(0);
    chk("R1 restart state", state, 1);
    chk("R1 restart clears shreg", shreg, 0);
    strobe(1);

    write_word(4, 8'hB5, 1, 1);
    read_word(4, 8'hB5);
    write_word(4, 8'h4A, 1, 0);
    read_word(4, 8'hB5);
    write_word(3, 8'h3C, 0, 0);
    read_word(3, 8'h00);
    write_word(3, 8'h3C, 1, 1);
    read_word(3, 8'h3C);
    write_word(1, 8'hFF, 1, 0);
    write_word(2, 8'hFF, 1, 0);
    write_word(5, 8'hFF, 1, 0);
    write_word(6, 8'hFF, 1, 0);
    read_word(5, 8'h00);
    read_word(6, TC);

    strobe(0);
    gap_pulse(820);
    repeat (TO - 1) @(negedge clk);
    chk("R8 still active before timeout", state, 1);
    @(negedge clk);
    chk("R8 timeout ends session", state, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule